// File: doc/BRIEF.md
# Iterative AES-128 Inverse Cipher

This block turns one 128-bit AES-128 ciphertext back into its plaintext. It finishes one inverse round per clock. The caller presents the ciphertext together with the last round key that the forward key expansion produced, rather than the original cipher key. The core then walks the key expansion backwards, producing one earlier round key per cycle, while the data path applies the inverse round operations to the state.

A block is accepted while `load` is high and the core waits for `load` to fall. Ten round cycles follow. The recovered block then sits in an output register with `done` high until the next `load`.

Byte `k` of a 128-bit port is bits `[127-8k -: 8]`. Byte `r + 4c` sits in row `r`, column `c` of the state.

The controller has four states:
- IDLE: reached from reset.
- HOLD: entered from any state whenever `load` is 1. The core stays in HOLD while `load` stays 1.
- ROUND: entered from HOLD when `load` is 0. The core stays in ROUND for ten cycles.
- DONE: entered from ROUND after the tenth round. The core stays in DONE until `load` is 1.

Top module: `aes128_dec_core`

## Requirements
- R1: While and after reset, and before any load, `done` is 0 and `pt_out` is all zeros.
- R2: A block is captured at each rising edge where `load` is 1, and no round runs while `load` stays 1. `done` rises exactly at the 11th rising edge after the last edge that sampled `load` high, and it is 0 at every edge before that.
- R3: The byte order is column-major: port byte `r+4c` is state row `r`, column `c`. For the known key `000102030405060708090a0b0c0d0e0f`, the round-10 key is `13111d7fe3944a17f307a78b4d2b30c5`. Given that round-10 key and ciphertext `69c4e0d86a7b0430d8cdb78070b4c55a`, the result is `00112233445566778899aabbccddeeff`.
- R4: For any cipher key and plaintext, loading the forward ciphertext and the forward round-10 key yields the original plaintext. The earlier keys are rebuilt backwards, using round constants from 36 down to 01.
- R5: Once `done` is 1, both `done` and `pt_out` keep their values at every edge until an edge where `load` is 1. After that edge `done` is 0.
- R6: A `load` that arrives during the ROUND state abandons the current block and restarts with the newly loaded data. The new block's timing follows R2.
- R7: `pt_out` changes only at the edge that completes the tenth round. It keeps the previous result while a new block is held or processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture strobe for `ct_in` and `key_in`; rounds begin after it falls |
| ct_in | input | 128 | Ciphertext block, byte 0 in bits 127:120 |
| key_in | input | 128 | Round-10 key of the forward key expansion |
| pt_out | output | 128 | Recovered plaintext, held until the next completion |
| done | output | 1 | High from completion until the next load |

## Verification
A wrong internal state would show only at completion, because the round state and the round key stay inside the core.
- Any error in the inverse S-box, in the row rotation, in the column mixing or in one backward key step spreads through the remaining rounds. The result is a `pt_out` that differs in many bytes, visible at the edge that raises `done`.
- A wrong round counter or a wrong state transition moves the rise of `done` off the 11th edge. It is therefore caught one cycle early or late by the timing checks run for every block.
- A fault in the DONE hold shows within one cycle as a change of `pt_out` or a fall of `done` without a load.

// File: rtl/aes_dec_pkg.sv
`timescale 1ns/1ps
package aes_dec_pkg;

    localparam int BLK_W  = 128;
    localparam int BYTE_W = 8;
    localparam int NBYTES = BLK_W / BYTE_W;
    localparam int NCOLS  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_ROUND = 2'd2,
        ST_DONE  = 2'd3
    } dec_state_e;

    // byte k of a block lives in bits [127-8k -: 8]
    function automatic logic [7:0] blk_byte(input logic [127:0] v, input int idx);
        return v[127 - 8*idx -: 8];
    endfunction

    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as x^254 (zero maps to zero)
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] sq;
        logic [7:0] acc;
        sq  = x;
        acc = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] fwd_sbox(input logic [7:0] x);
        logic [7:0] b;
        b = gf_inv(x);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] inv_sbox(input logic [7:0] s);
        logic [7:0] b;
        b = rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
        return gf_inv(b);
    endfunction

    // round constant for round r (1 -> 01, 10 -> 36)
    function automatic logic [7:0] rcon_of(input logic [3:0] r);
        logic [7:0] c;
        c = 8'h01;
        for (int i = 1; i < 10; i++) begin
            if (i < int'(r)) c = gf_dbl(c);
        end
        return c;
    endfunction

endpackage

// File: rtl/aes_inv_round.sv
`timescale 1ns/1ps
module aes_inv_round
    import aes_dec_pkg::*;
(
    input  logic [127:0] state_in,
    input  logic [127:0] rkey,
    input  logic         final_rnd,
    output logic [127:0] state_out
);
    logic [127:0] shifted;
    logic [127:0] substituted;
    logic [127:0] keyed;
    logic [127:0] mixed;

    // inverse row rotation and inverse substitution, byte by byte
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int DST = r + 4*c;
            localparam int SRC = r + 4*((c - r + 4) % 4);
            assign shifted[127 - 8*DST -: 8]     = state_in[127 - 8*SRC -: 8];
            assign substituted[127 - 8*DST -: 8] = inv_sbox(shifted[127 - 8*DST -: 8]);
        end

        assign keyed[127 - 32*c -: 32] = substituted[127 - 32*c -: 32] ^ rkey[127 - 32*c -: 32];

        // inverse column mix with coefficients 0e 0b 0d 09
        logic [7:0] a0, a1, a2, a3;
        assign a0 = keyed[127 - 32*c -: 8];
        assign a1 = keyed[119 - 32*c -: 8];
        assign a2 = keyed[111 - 32*c -: 8];
        assign a3 = keyed[103 - 32*c -: 8];
        assign mixed[127 - 32*c -: 8] = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
        assign mixed[119 - 32*c -: 8] = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
        assign mixed[111 - 32*c -: 8] = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
        assign mixed[103 - 32*c -: 8] = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
    end

    assign state_out = final_rnd ? keyed : mixed;

endmodule

// File: rtl/aes_key_back.sv
`timescale 1ns/1ps
module aes_key_back
    import aes_dec_pkg::*;
(
    input  logic [127:0] key_cur,
    input  logic [3:0]   rnd,
    output logic [127:0] key_prev
);
    logic [31:0] w0, w1, w2, w3;
    logic [31:0] p1, p2, p3;
    logic [31:0] rot;
    logic [31:0] subw;

    assign w0 = key_cur[127:96];
    assign w1 = key_cur[95:64];
    assign w2 = key_cur[63:32];
    assign w3 = key_cur[31:0];

    // the last three words of the earlier key fall out by pairwise XOR
    assign p3 = w3 ^ w2;
    assign p2 = w2 ^ w1;
    assign p1 = w1 ^ w0;

    assign rot = {p3[23:0], p3[31:24]};
    for (genvar b = 0; b < 4; b++) begin : g_sub
        assign subw[31 - 8*b -: 8] = fwd_sbox(rot[31 - 8*b -: 8]);
    end

    assign key_prev = {w0 ^ subw ^ {rcon_of(rnd), 24'h0}, p1, p2, p3};

endmodule

// File: rtl/aes_dec_fsm.sv
`timescale 1ns/1ps
module aes_dec_fsm
    import aes_dec_pkg::*;
#(
    parameter int NR = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    output logic                     capture,
    output logic                     step,
    output logic                     last,
    output logic [$clog2(NR+1)-1:0]  rnd,
    output logic                     busy_done
);
    localparam int CW = $clog2(NR + 1);

    dec_state_e state_q, state_d;
    logic [CW-1:0] rnd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = load ? ST_HOLD : ST_IDLE;
            ST_HOLD:  state_d = load ? ST_HOLD : ST_ROUND;
            ST_ROUND: state_d = load ? ST_HOLD : ((rnd_q == CW'(1)) ? ST_DONE : ST_ROUND);
            ST_DONE:  state_d = load ? ST_HOLD : ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rnd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)
                rnd_q <= CW'(NR);
            else if (state_q == ST_ROUND)
                rnd_q <= rnd_q - CW'(1);
        end
    end

    always_comb begin
        capture   = load;
        step      = (state_q == ST_ROUND) && !load;
        last      = step && (rnd_q == CW'(1));
        rnd       = rnd_q;
        busy_done = (state_q == ST_DONE);
    end

    // R7: the round counter stays inside 1..NR while rounds run
    a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROUND) |-> (rnd_q >= CW'(1) && rnd_q <= CW'(NR)));

    // R2: a load always leads to HOLD
    a_r2_load_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == ST_HOLD));

endmodule

// File: rtl/aes128_dec_core.sv
`timescale 1ns/1ps
module aes128_dec_core
    import aes_dec_pkg::*;
#(
    parameter int NR = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [127:0] ct_in,
    input  logic [127:0] key_in,
    output logic [127:0] pt_out,
    output logic         done
);
    localparam int CW = $clog2(NR + 1);

    logic          capture, step, last, fsm_done;
    logic [CW-1:0] rnd;
    logic [127:0]  st_q, rk_q, pt_q;
    logic [127:0]  rk_prev, st_next;

    aes_dec_fsm #(.NR(NR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .capture   (capture),
        .step      (step),
        .last      (last),
        .rnd       (rnd),
        .busy_done (fsm_done)
    );

    aes_key_back u_key (
        .key_cur  (rk_q),
        .rnd      (4'(rnd)),
        .key_prev (rk_prev)
    );

    aes_inv_round u_round (
        .state_in  (st_q),
        .rkey      (rk_prev),
        .final_rnd (last),
        .state_out (st_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            rk_q <= '0;
            pt_q <= '0;
        end else if (capture) begin
            st_q <= ct_in ^ key_in;   // opening key addition with the round-10 key
            rk_q <= key_in;
        end else if (step) begin
            st_q <= st_next;
            rk_q <= rk_prev;
            if (last) pt_q <= st_next;
        end
    end

    assign pt_out = pt_q;
    assign done   = fsm_done;

    // R5: a finished result holds until a load
    a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> (done && $stable(pt_out)));

    // R5: done only falls after a load
    a_r5_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(load));

    // R2: no completion directly after a capture
    a_r2_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);

    // R7: the output register is untouched by non-final rounds
    a_r7_pt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last) |=> $stable(pt_out));

endmodule

// File: tb/sim_aes128_dec_core.sv
`timescale 1ns/1ps
module sim_aes128_dec_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [127:0] ct_in = '0;
    logic [127:0] key_in = '0;
    logic [127:0] pt_out;
    logic         done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    logic [7:0] sb [256];

    always #4 clk = ~clk;

    aes128_dec_core u0 (
        .clk(clk), .rst_n(rst_n), .load(load),
        .ct_in(ct_in), .key_in(key_in), .pt_out(pt_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            summary();
        end
    end

    // ---------------- behavioural forward cipher ----------------
    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = 0;
        for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
        for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h11b << (i - 8);
        return p[7:0];
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            sb[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        end
    endtask

    task automatic encrypt(input logic [127:0] pt, input logic [127:0] key,
                           output logic [127:0] ct, output logic [127:0] k10);
        logic [31:0] w [44];
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [7:0] rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127 - 32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]} ^ {rc, 24'h0};
                rc = bmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int k = 0; k < 16; k++) s[k] = pt[127 - 8*k -: 8] ^ w[k/4][31 - 8*(k%4) -: 8];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int k = 0; k < 16; k++) begin
                int r = k % 4;
                int c = k / 4;
                t[k] = sb[s[r + 4*((c + r) % 4)]];
            end
            for (int c = 0; c < 4; c++) begin
                logic [7:0] a0 = t[4*c], a1 = t[4*c+1], a2 = t[4*c+2], a3 = t[4*c+3];
                if (rnd != 10) begin
                    t[4*c]   = bmul(a0,2) ^ bmul(a1,3) ^ a2 ^ a3;
                    t[4*c+1] = a0 ^ bmul(a1,2) ^ bmul(a2,3) ^ a3;
                    t[4*c+2] = a0 ^ a1 ^ bmul(a2,2) ^ bmul(a3,3);
                    t[4*c+3] = bmul(a0,3) ^ a1 ^ a2 ^ bmul(a3,2);
                end
            end
            for (int k = 0; k < 16; k++) s[k] = t[k] ^ w[4*rnd + k/4][31 - 8*(k%4) -: 8];
        end
        for (int k = 0; k < 16; k++) ct[127 - 8*k -: 8] = s[k];
        k10 = {w[40], w[41], w[42], w[43]};
    endtask

    // ---------------- per-cycle driver and reference ----------------
    // drives one block with load high for 'hold' edges, then checks each later edge
    task automatic run_block(input logic [127:0] ct, input logic [127:0] k10,
                             input logic [127:0] exp_pt, input logic [127:0] prev_pt,
                             input int hold, input string req);
        @(negedge clk);
        load = 1'b1; ct_in = ct; key_in = k10;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(done == 1'b0, "R2 done low while load held", 128'(done), 128'(0));
            chk(pt_out == prev_pt, "R7 pt kept while held", pt_out, prev_pt);
        end
        load = 1'b0; ct_in = '0; key_in = '0;
        for (int i = 1; i <= 11; i++) begin
            @(negedge clk);
            chk(done == (i == 11), "R2 done timing", 128'(i), 128'(11));
            if (i < 11) chk(pt_out == prev_pt, "R7 pt kept during rounds", pt_out, prev_pt);
        end
        chk(pt_out == exp_pt, req, pt_out, exp_pt);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(done == 1'b1 && pt_out == exp_pt, "R5 result held", pt_out, exp_pt);
        end
    endtask

    initial begin
        logic [127:0] ct, k10, last_pt;
        build_sbox();

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && pt_out == '0, "R1 reset", pt_out, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && pt_out == '0, "R1 after reset", pt_out, '0);

        // R3: known vector, model and core
        encrypt(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, ct, k10);
        chk(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 model ciphertext", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk(k10 == 128'h13111d7fe3944a17f307a78b4d2b30c5, "R3 model round key", k10, 128'h13111d7fe3944a17f307a78b4d2b30c5);
        run_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h13111d7fe3944a17f307a78b4d2b30c5,
                  128'h00112233445566778899aabbccddeeff, '0, 1, "R3 known vector");
        last_pt = 128'h00112233445566778899aabbccddeeff;

        // R4: random blocks with varied load lengths (R2)
        for (int n = 0; n < 12; n++) begin
            logic [127:0] p, k;
            p = {$urandom, $urandom, $urandom, $urandom};
            k = {$urandom, $urandom, $urandom, $urandom};
            if (n == 0) k = '0;
            if (n == 1) p = '1;
            encrypt(p, k, ct, k10);
            run_block(ct, k10, p, last_pt, 1 + (n % 3), "R4 random block");
            last_pt = p;
        end

        // R6: restart mid-run with a new block
        begin
            logic [127:0] pa, pb, ka, kb, cta, ka10, ctb, kb10;
            pa = {$urandom, $urandom, $urandom, $urandom};
            ka = {$urandom, $urandom, $urandom, $urandom};
            pb = {$urandom, $urandom, $urandom, $urandom};
            kb = {$urandom, $urandom, $urandom, $urandom};
            encrypt(pa, ka, cta, ka10);
            encrypt(pb, kb, ctb, kb10);
            @(negedge clk);
            load = 1'b1; ct_in = cta; key_in = ka10;
            @(negedge clk);
            load = 1'b0;
            @(negedge clk);
            chk(done == 1'b0, "R5 done cleared by load", 128'(done), 128'(0));
            repeat (4) @(negedge clk);
            run_block(ctb, kb10, pb, last_pt, 1, "R6 restart result");
        end

        summary();
    end

endmodule